// File: doc/BRIEF.md
# E1 Multiframe Transmit Framer

This block produces the transmit side of a 2.048 Mbit/s primary-rate stream as NRZ serial data. Each frame has 32 eight-bit timeslots, and sixteen frames make one multiframe. Slot 0 alternates between the alignment pattern on even frames and a service byte on odd frames. The service byte carries a remote alarm flag and five national spare bits. Slot 16 carries the multiframe marker and the distant multiframe alarm in frame 0. In every later frame, slot 16 carries the four-bit signalling codes of two voice channels. Each remaining slot carries one of 30 channel bytes.

Channel bytes and signalling codes come from storage outside the block. The framer drives channel indices one timeslot ahead of use and samples the returned values on the last bit of the slot before. The framer advances by one bit whenever the line bit enable is high. It holds its output between enables. Frame and multiframe start strobes mark the first bit of each frame and of each multiframe.

Top module: `e1_mf_framer`

## Requirements
- R1: Each timeslot is sent most significant bit first, one bit per clock with `bit_en` high, 8 enables per slot and 32 slots per frame. `line_o` changes only on a clock edge where `bit_en` is high.
- R2: Slot t for t in 1..15 carries channel t, and slot t for t in 17..31 carries channel t-1. The channel index output is always within 1..30 when `ch_rd_o` is high and is 0 otherwise.
- R3: Slot 0 of every even frame (0,2,..,14) is sent as 8'b1001_1011.
- R4: Slot 0 of every odd frame is sent as {1, 1, remote_alarm_i, spare_i[4:0]}, where spare_i[4] is the first spare bit on the line.
- R5: Slot 16 of frame 0 is sent as {4'b0000, 1, mf_alarm_i, 1, 1}.
- R6: Slot 16 of frame n (1..15) is sent as {sig_lo_i, sig_hi_i}. At that time `sig_lo_idx_o` = n and `sig_hi_idx_o` = n+15, and both indices are 0 outside that fetch.
- R7: While slot s is being sent, `ch_idx_o` gives the channel of slot s+1. Its byte is sampled on the enable of the last bit of slot s.
- R8: `frame_start_o` is high for one clock after the enable that sends the first bit of slot 0 of any frame. `mframe_start_o` does the same only in frame 0.
- R9: After reset `line_o` and both strobes are 0 and `ch_idx_o` = 1. The first byte sent is slot 0 of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Advance one line bit |
| ch_idx_o | output | 5 | Channel index for the next slot (0 = none) |
| ch_rd_o | output | 1 | Next slot needs a channel byte |
| ch_byte_i | input | 8 | Channel byte for `ch_idx_o` |
| sig_lo_idx_o | output | 5 | Channel whose code fills bits 1-4 of slot 16 |
| sig_hi_idx_o | output | 5 | Channel whose code fills bits 5-8 of slot 16 |
| sig_lo_i | input | 4 | Signalling code for `sig_lo_idx_o` |
| sig_hi_i | input | 4 | Signalling code for `sig_hi_idx_o` |
| remote_alarm_i | input | 1 | Remote alarm flag for odd-frame slot 0 |
| mf_alarm_i | input | 1 | Distant multiframe alarm for frame-0 slot 16 |
| spare_i | input | 5 | Spare bits for odd-frame slot 0 |
| line_o | output | 1 | NRZ serial data |
| frame_start_o | output | 1 | First bit of a frame strobe |
| mframe_start_o | output | 1 | First bit of a multiframe strobe |

## Verification
Some properties can be checked on every cycle, and the assertions cover those. The line bit holds between enables. The position counters wrap correctly. The channel index stays in range. The two signalling indices keep their offset of 15. The strobes are single-clock pulses, the multiframe strobe never appears without the frame strobe, and they coincide with the first bit of slot 0. Other behaviour can only be shown by the bench scenarios. These are the content of each slot across whole multiframes, the alternating slot-0 bytes, the slot-16 rotation, the one-slot-ahead index timing, and the continuation across a multiframe wrap with irregular enables.

// File: rtl/e1_framer_pkg.sv
package e1_framer_pkg;
    localparam int E1_SLOTS  = 32;
    localparam int E1_FRAMES = 16;
    localparam int E1_BITS   = 8;
    localparam logic [7:0] ALIGN_BYTE = 8'b1001_1011;
endpackage

// File: rtl/e1_pos_ctr.sv
module e1_pos_ctr #(
    parameter int SLOTS  = 32,
    parameter int FRAMES = 16,
    parameter int BITS   = 8,
    localparam int BW = $clog2(BITS),
    localparam int SW = $clog2(SLOTS),
    localparam int FW = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [BW-1:0] bit_o,
    output logic [SW-1:0] slot_o,
    output logic [FW-1:0] frame_o,
    output logic [SW-1:0] nslot_o,
    output logic [FW-1:0] nframe_o,
    output logic          first_bit_o,
    output logic          last_bit_o
);
    localparam logic [BW-1:0] B_LAST = BW'(BITS - 1);
    localparam logic [SW-1:0] S_LAST = SW'(SLOTS - 1);
    localparam logic [FW-1:0] F_LAST = FW'(FRAMES - 1);

    typedef struct packed {
        logic [BW-1:0] bpos;
        logic [SW-1:0] spos;
        logic [FW-1:0] fpos;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (step) begin
            if (pos_q.bpos == B_LAST) begin
                pos_d.bpos = '0;
                if (pos_q.spos == S_LAST) begin
                    pos_d.spos = '0;
                    pos_d.fpos = (pos_q.fpos == F_LAST) ? '0 : pos_q.fpos + 1'b1;
                end else begin
                    pos_d.spos = pos_q.spos + 1'b1;
                end
            end else begin
                pos_d.bpos = pos_q.bpos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign bit_o       = pos_q.bpos;
    assign slot_o      = pos_q.spos;
    assign frame_o     = pos_q.fpos;
    assign first_bit_o = (pos_q.bpos == '0);
    assign last_bit_o  = (pos_q.bpos == B_LAST);
    assign nslot_o     = (pos_q.spos == S_LAST) ? '0 : pos_q.spos + 1'b1;
    assign nframe_o    = (pos_q.spos != S_LAST) ? pos_q.fpos :
                         ((pos_q.fpos == F_LAST) ? '0 : pos_q.fpos + 1'b1);

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && pos_q.bpos == B_LAST && pos_q.spos == S_LAST) |=> (pos_q.spos == '0)); // R1
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pos_q)); // R1
endmodule

// File: rtl/e1_slot_builder.sv
module e1_slot_builder #(
    parameter int SLOTS  = 32,
    parameter int FRAMES = 16,
    parameter int BITS   = 8,
    parameter logic [BITS-1:0] ALIGN = 8'b1001_1011,
    localparam int SW  = $clog2(SLOTS),
    localparam int FW  = $clog2(FRAMES),
    localparam int NW  = BITS / 2,
    localparam int SPW = BITS - 3
) (
    input  logic [SW-1:0]   nslot_i,
    input  logic [FW-1:0]   nframe_i,
    input  logic [BITS-1:0] ch_byte_i,
    input  logic [NW-1:0]   sig_lo_i,
    input  logic [NW-1:0]   sig_hi_i,
    input  logic            remote_alarm_i,
    input  logic            mf_alarm_i,
    input  logic [SPW-1:0]  spare_i,
    output logic [BITS-1:0] byte_o,
    output logic [SW-1:0]   ch_idx_o,
    output logic            ch_rd_o,
    output logic [SW-1:0]   sig_lo_idx_o,
    output logic [SW-1:0]   sig_hi_idx_o
);
    localparam logic [SW-1:0] SIG_SLOT = SW'(SLOTS / 2);
    localparam logic [SW-1:0] PAIR_OFS = SW'(SLOTS / 2 - 1);

    logic is_align, is_sig, is_mf0;

    always_comb begin
        is_align = (nslot_i == '0);
        is_sig   = (nslot_i == SIG_SLOT);
        is_mf0   = (nframe_i == '0);

        ch_rd_o  = !is_align && !is_sig;
        if (!ch_rd_o)               ch_idx_o = '0;
        else if (nslot_i < SIG_SLOT) ch_idx_o = nslot_i;
        else                         ch_idx_o = nslot_i - 1'b1;

        if (is_sig && !is_mf0) begin
            sig_lo_idx_o = SW'(nframe_i);
            sig_hi_idx_o = SW'(nframe_i) + PAIR_OFS;
        end else begin
            sig_lo_idx_o = '0;
            sig_hi_idx_o = '0;
        end

        if (is_align) begin
            if (!nframe_i[0]) byte_o = ALIGN;
            else              byte_o = {2'b11, remote_alarm_i, spare_i};
        end else if (is_sig) begin
            if (is_mf0) byte_o = {{NW{1'b0}}, 1'b1, mf_alarm_i, {(NW-2){1'b1}}};
            else        byte_o = {sig_lo_i, sig_hi_i};
        end else begin
            byte_o = ch_byte_i;
        end
    end
endmodule

// File: rtl/e1_bit_shifter.sv
module e1_bit_shifter #(
    parameter int BITS = 8,
    parameter logic [BITS-1:0] RESET_BYTE = 8'b1001_1011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            first_bit_i,
    input  logic            last_bit_i,
    input  logic            frame_head_i,
    input  logic            mframe_head_i,
    input  logic [BITS-1:0] next_byte_i,
    output logic            ser_o,
    output logic            fs_o,
    output logic            mfs_o
);
    typedef struct packed {
        logic            ser;
        logic            fs;
        logic            mfs;
        logic [BITS-1:0] sh;
        logic [BITS-1:0] pre;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d     = sh_q;
        sh_d.fs  = 1'b0;
        sh_d.mfs = 1'b0;
        if (step) begin
            if (first_bit_i) begin
                sh_d.ser = sh_q.pre[BITS-1];
                sh_d.sh  = {sh_q.pre[BITS-2:0], 1'b0};
                sh_d.fs  = frame_head_i;
                sh_d.mfs = frame_head_i && mframe_head_i;
            end else begin
                sh_d.ser = sh_q.sh[BITS-1];
                sh_d.sh  = {sh_q.sh[BITS-2:0], 1'b0};
            end
            if (last_bit_i) sh_d.pre = next_byte_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            sh_q.pre <= RESET_BYTE;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign ser_o = sh_q.ser;
    assign fs_o  = sh_q.fs;
    assign mfs_o = sh_q.mfs;

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(sh_q.ser)); // R1
    AST_MF_NEEDS_FS: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.mfs |-> sh_q.fs); // R8
    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.fs |=> !sh_q.fs); // R8
endmodule

// File: rtl/e1_mf_framer.sv
module e1_mf_framer
    import e1_framer_pkg::*;
#(
    parameter int SLOTS  = E1_SLOTS,
    parameter int FRAMES = E1_FRAMES,
    parameter int BITS   = E1_BITS,
    localparam int SW  = $clog2(SLOTS),
    localparam int FW  = $clog2(FRAMES),
    localparam int BW  = $clog2(BITS),
    localparam int NW  = BITS / 2,
    localparam int SPW = BITS - 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    output logic [SW-1:0]   ch_idx_o,
    output logic            ch_rd_o,
    input  logic [BITS-1:0] ch_byte_i,
    output logic [SW-1:0]   sig_lo_idx_o,
    output logic [SW-1:0]   sig_hi_idx_o,
    input  logic [NW-1:0]   sig_lo_i,
    input  logic [NW-1:0]   sig_hi_i,
    input  logic            remote_alarm_i,
    input  logic            mf_alarm_i,
    input  logic [SPW-1:0]  spare_i,
    output logic            line_o,
    output logic            frame_start_o,
    output logic            mframe_start_o
);
    logic [BW-1:0]   bit_pos;
    logic [SW-1:0]   slot_pos, nslot;
    logic [FW-1:0]   frame_pos, nframe;
    logic            first_bit, last_bit;
    logic [BITS-1:0] next_byte;

    e1_pos_ctr #(.SLOTS(SLOTS), .FRAMES(FRAMES), .BITS(BITS)) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (bit_en),
        .bit_o       (bit_pos),
        .slot_o      (slot_pos),
        .frame_o     (frame_pos),
        .nslot_o     (nslot),
        .nframe_o    (nframe),
        .first_bit_o (first_bit),
        .last_bit_o  (last_bit)
    );

    e1_slot_builder #(.SLOTS(SLOTS), .FRAMES(FRAMES), .BITS(BITS),
                      .ALIGN(BITS'(ALIGN_BYTE))) u_build (
        .nslot_i        (nslot),
        .nframe_i       (nframe),
        .ch_byte_i      (ch_byte_i),
        .sig_lo_i       (sig_lo_i),
        .sig_hi_i       (sig_hi_i),
        .remote_alarm_i (remote_alarm_i),
        .mf_alarm_i     (mf_alarm_i),
        .spare_i        (spare_i),
        .byte_o         (next_byte),
        .ch_idx_o       (ch_idx_o),
        .ch_rd_o        (ch_rd_o),
        .sig_lo_idx_o   (sig_lo_idx_o),
        .sig_hi_idx_o   (sig_hi_idx_o)
    );

    e1_bit_shifter #(.BITS(BITS), .RESET_BYTE(BITS'(ALIGN_BYTE))) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .step          (bit_en),
        .first_bit_i   (first_bit),
        .last_bit_i    (last_bit),
        .frame_head_i  (slot_pos == '0),
        .mframe_head_i (frame_pos == '0),
        .next_byte_i   (next_byte),
        .ser_o         (line_o),
        .fs_o          (frame_start_o),
        .mfs_o         (mframe_start_o)
    );

    AST_CH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ch_rd_o |-> (ch_idx_o >= SW'(1) && ch_idx_o <= SW'(SLOTS - 2))); // R2
    AST_SIG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_lo_idx_o != '0) |-> (sig_hi_idx_o == sig_lo_idx_o + SW'(SLOTS / 2 - 1))); // R6
    AST_FS_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (slot_pos == '0 && bit_pos == BW'(1))); // R8
endmodule

// File: tb/e1_mf_framer_test.sv
module e1_mf_framer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [4:0] ch_idx, sig_lo_idx, sig_hi_idx;
    logic       ch_rd;
    logic [7:0] ch_byte;
    logic [3:0] sig_lo, sig_hi;
    logic       rai = 1'b0, dmfa = 1'b0;
    logic [4:0] spare = 5'h1F;
    logic       line, fs, mfs;
    int         seed = 0;
    int         checks = 0;
    int         failures = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] chdat(input int c, input int sd);
        return 8'((c * 37 + sd) & 255);
    endfunction
    function automatic logic [3:0] nib(input int c, input int sd);
        return 4'((c * 5 + sd) & 15);
    endfunction

    assign ch_byte = chdat(int'(ch_idx), seed);
    assign sig_lo  = nib(int'(sig_lo_idx), seed);
    assign sig_hi  = nib(int'(sig_hi_idx), seed);

    e1_mf_framer uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_en         (bit_en),
        .ch_idx_o       (ch_idx),
        .ch_rd_o        (ch_rd),
        .ch_byte_i      (ch_byte),
        .sig_lo_idx_o   (sig_lo_idx),
        .sig_hi_idx_o   (sig_hi_idx),
        .sig_lo_i       (sig_lo),
        .sig_hi_i       (sig_hi),
        .remote_alarm_i (rai),
        .mf_alarm_i     (dmfa),
        .spare_i        (spare),
        .line_o         (line),
        .frame_start_o  (fs),
        .mframe_start_o (mfs)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int chan_of(input int s);
        if (s == 0 || s == 16) return 0;
        return (s < 16) ? s : s - 1;
    endfunction

    function automatic logic [7:0] exp_byte(input int f, input int s);
        if (s == 0) return (f % 2 == 0) ? 8'b1001_1011 : {2'b11, rai, spare};
        if (s == 16) begin
            if (f == 0) return {4'b0000, 1'b1, dmfa, 2'b11};
            return {nib(f, seed), nib(f + 15, seed)};
        end
        return chdat(chan_of(s), seed);
    endfunction

    task automatic do_reset();
        bit_en = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Sends one whole multiframe and checks every slot; gap = idle clocks per bit
    task automatic run_mf(input int gap);
        for (int f = 0; f < 16; f++) begin
            for (int s = 0; s < 32; s++) begin
                logic [7:0] got = '0;
                bit hold_ok = 1'b1;
                for (int b = 0; b < 8; b++) begin
                    logic v;
                    bit_en = 1'b1;
                    @(negedge clk);
                    bit_en = 1'b0;
                    v   = line;
                    got = {got[6:0], v};
                    if (b == 0) begin
                        check(fs == (s == 0), "R8 frame strobe", int'(fs), int'(s == 0));
                        check(mfs == (s == 0 && f == 0), "R8 multiframe strobe",
                              int'(mfs), int'(s == 0 && f == 0));
                        check(int'(ch_idx) == chan_of((s + 1) % 32), "R7 R2 next index",
                              int'(ch_idx), chan_of((s + 1) % 32));
                        if ((s + 1) % 32 == 16 && f != 0) begin
                            check(int'(sig_lo_idx) == f && int'(sig_hi_idx) == f + 15,
                                  "R6 signalling index", int'(sig_lo_idx), f);
                        end
                    end
                    for (int g = 0; g < gap; g++) begin
                        @(negedge clk);
                        if (line != v || fs || mfs) hold_ok = 1'b0;
                    end
                end
                if (gap > 0) check(hold_ok, "R1 hold between enables", 0, 1);
                if (s == 0 && f % 2 == 0)
                    check(got == exp_byte(f, s), "R3 align byte", int'(got), int'(exp_byte(f, s)));
                else if (s == 0)
                    check(got == exp_byte(f, s), "R4 service byte", int'(got), int'(exp_byte(f, s)));
                else if (s == 16 && f == 0)
                    check(got == exp_byte(f, s), "R5 multiframe marker", int'(got), int'(exp_byte(f, s)));
                else if (s == 16)
                    check(got == exp_byte(f, s), "R6 signalling byte", int'(got), int'(exp_byte(f, s)));
                else
                    check(got == exp_byte(f, s), "R1 R2 channel byte", int'(got), int'(exp_byte(f, s)));
            end
        end
    endtask

    task automatic test_reset();
        seed = 9;
        do_reset();
        check(line == 1'b0, "R9 line after reset", int'(line), 0);
        check(fs == 1'b0 && mfs == 1'b0, "R9 strobes after reset", int'({fs, mfs}), 0);
        check(ch_idx == 5'd1 && ch_rd, "R9 R7 first index", int'(ch_idx), 1);
        check(sig_lo_idx == 5'd0 && sig_hi_idx == 5'd0, "R6 idle signalling index",
              int'(sig_lo_idx), 0);
    endtask

    task automatic test_plain();
        seed = 3; rai = 1'b0; dmfa = 1'b0; spare = 5'h1F;
        do_reset();
        run_mf(0);
    endtask

    task automatic test_alarms_gaps();
        seed = 8'h5A; rai = 1'b1; dmfa = 1'b1; spare = 5'b01010;
        do_reset();
        run_mf(2);
    endtask

    task automatic test_wrap();
        seed = 8'h11; rai = 1'b0; dmfa = 1'b1; spare = 5'b10011;
        do_reset();
        run_mf(0);
        run_mf(1);
    endtask

    initial begin
        test_reset();
        test_plain();
        test_alarms_gaps();
        test_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule